// File: doc/BRIEF.md
# Dual-Bank Flash Operation Scheduler

This block sequences work on a data store made of two banks that can each be busy on their own. A bank can be read, programmed one page at a time, or erased by sector. Requests come in on a command stream. The scheduler decides which requests may run side by side and rejects the rest. The cell timing is modelled by down-counters, so a program lasts a fixed number of cycles derived from the page size, and an erase lasts a configurable number of cycles.

The scheduler also handles the case where a program arrives for one bank while the other bank is erasing. It freezes the erase without software help, lets the program run, and then continues the erase from the count it had reached. Completions, refused reads and illegal requests each set a sticky flag. Flags can be masked from the interrupt line and are cleared one bit at a time.

The command stream never applies back-pressure. Once reset is released, `cmd_ready` stays high, and a request is taken on every clock edge where `cmd_valid` is high. A request that cannot run is dropped and reported through a flag; it is never held back. A read has no data path here: the scheduler only grants it.

Top module: `flash_bank_sched`

## Requirements
- R1: While `rst_n` is low, `cmd_ready` is low, and all status bits, flags, `rd_grant` and `irq` are low. After reset is released, `cmd_ready` is high from the next clock edge.
- R2: A program request (`cmd_op`=2'b10) to an idle bank is accepted when the other bank is not programming. From the cycle after acceptance, the bank shows busy and programming for exactly PAGE_BYTES/WORD_BYTES*CYC_PER_WORD cycles. It then returns to idle and sets the done flag (flag bit 0).
- R3: An erase request (`cmd_op`=2'b11) to an idle bank is accepted when the other bank is not erasing. The bank shows erasing for exactly ERASE_CYCLES cycles in total, then returns to idle and sets the done flag.
- R4: If a program is accepted on one bank while the other bank is erasing, the erasing bank shows suspended (not erasing) for exactly the program duration. It then resumes from its remaining count, so its total erasing cycles still equal ERASE_CYCLES.
- R5: An erase accepted while the other bank is programming starts in the suspended state. It begins erasing when that program ends.
- R6: A read request (`cmd_op`=2'b01) to an idle bank pulses `rd_grant` for one cycle, in the cycle after acceptance. A read to a bank that is programming, erasing or suspended gives no grant and sets the access-error flag (flag bit 1).
- R7: A program or erase request to a bank that is already busy sets the sequence-error flag (flag bit 2). It does not restart or change the running operation.
- R8: A program request while the other bank is programming, or an erase request while the other bank is erasing, sets the sequence-error flag and is otherwise ignored.
- R9: Flags are sticky. A `flag_clr` bit clears its flag, but a set in the same cycle wins. `irq` is high when any flag is set whose `flag_mask` bit is low.
- R10: `cmd_op`=2'b00 is a no-operation: it grants nothing, changes no bank state and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken (high whenever out of reset) |
| cmd_op | input | 2 | 00 none, 01 read, 10 program page, 11 erase sector |
| cmd_bank | input | 1 | Target bank |
| rd_grant | output | 1 | One-cycle pulse: read accepted |
| bank_busy | output | 2 | Per-bank busy |
| bank_erasing | output | 2 | Per-bank erase in progress |
| bank_programming | output | 2 | Per-bank program in progress |
| bank_suspended | output | 2 | Per-bank erase frozen |
| flag_mask | input | 3 | 1 masks the matching flag from irq |
| flag_clr | input | 3 | 1 clears the matching flag this cycle |
| flags | output | 3 | bit0 done, bit1 access error, bit2 sequence error |
| irq | output | 1 | Any unmasked flag set |

## Verification
The bench builds the block with a 32-byte page, 8-byte words and one cycle per word, which gives a 4-cycle program, and with a 10-cycle erase. These short durations let a program fit inside an erase, with room before and after it. As a result, the suspend length, the resume from the remaining count, the held-start erase and the finishing-order cases can all be checked by counting status cycles in a few hundred clocks. The defaults (a 64-cycle program and a 2000-cycle erase) use the same counters and differ only in counter width.

// File: rtl/flash_sched_pkg.sv
package flash_sched_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_PROG  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_PROG,
    BK_ERASE,
    BK_ESUSP
  } bank_st_e;

  localparam int FLAG_DONE = 0;
  localparam int FLAG_ACC  = 1;
  localparam int FLAG_SEQ  = 2;
  localparam int NFLAGS    = 3;
endpackage

// File: rtl/fsch_bank.sv
module fsch_bank
  import flash_sched_pkg::*;
#(
  parameter int PROG_CYCLES  = 64,
  parameter int ERASE_CYCLES = 2000,
  parameter int CNT_W        = 11
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go_prog,
  input  logic     go_erase,
  input  logic     go_erase_held,
  input  logic     suspend,
  input  logic     resume,
  output bank_st_e st,
  output logic     prog_fin,
  output logic     erase_fin
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= BK_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        BK_IDLE: begin
          if (go_prog) begin
            st  <= BK_PROG;
            cnt <= CNT_W'(PROG_CYCLES - 1);
          end else if (go_erase) begin
            st  <= BK_ERASE;
            cnt <= CNT_W'(ERASE_CYCLES - 1);
          end else if (go_erase_held) begin
            st  <= BK_ESUSP;
            cnt <= CNT_W'(ERASE_CYCLES - 1);
          end
        end
        BK_PROG: begin
          if (cnt == '0) st <= BK_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        BK_ERASE: begin
          if (cnt == '0) st <= BK_IDLE;
          else begin
            cnt <= cnt - 1'b1;
            if (suspend) st <= BK_ESUSP;
          end
        end
        BK_ESUSP: begin
          if (resume) st <= BK_ERASE;
        end
        default: st <= BK_IDLE;
      endcase
    end
  end

  assign prog_fin  = (st == BK_PROG)  && (cnt == '0);
  assign erase_fin = (st == BK_ERASE) && (cnt == '0);

  // R4
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BK_ESUSP && !resume) |=> (st == BK_ESUSP && $stable(cnt)));

  // R2
  prog_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BK_PROG && cnt != '0) |=> (st == BK_PROG));
endmodule

// File: rtl/fsch_flags.sv
module fsch_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  input  logic [NF-1:0] mask,
  output logic [NF-1:0] flags,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end

  assign irq = |(flags & ~mask);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags & $past(set)) == $past(set)));
endmodule

// File: rtl/flash_bank_sched.sv
module flash_bank_sched
  import flash_sched_pkg::*;
#(
  parameter int PAGE_BYTES   = 128,
  parameter int WORD_BYTES   = 8,
  parameter int CYC_PER_WORD = 4,
  parameter int ERASE_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bank,
  output logic       rd_grant,
  output logic [1:0] bank_busy,
  output logic [1:0] bank_erasing,
  output logic [1:0] bank_programming,
  output logic [1:0] bank_suspended,
  input  logic [2:0] flag_mask,
  input  logic [2:0] flag_clr,
  output logic [2:0] flags,
  output logic       irq
);
  localparam int NBANKS      = 2;
  localparam int PROG_CYCLES = (PAGE_BYTES / WORD_BYTES) * CYC_PER_WORD;
  localparam int MAXC        = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W       = $clog2(MAXC + 1);

  bank_st_e          st [NBANKS];
  logic [NBANKS-1:0] prog_fin, erase_fin;
  logic [NBANKS-1:0] go_prog, go_erase, go_erase_held, suspend, resume;

  logic fire, tgt_busy, partner_prog_act, partner_erase_act;
  logic want_prog, want_erase, want_read;
  logic prog_ok, erase_ok, seq_err, acc_err, rd_ok;
  logic ptr;
  op_e  op;

  assign op   = op_e'(cmd_op);
  assign fire = cmd_valid && cmd_ready;
  assign ptr  = ~cmd_bank;

  always_comb begin
    tgt_busy          = (st[cmd_bank] != BK_IDLE);
    partner_prog_act  = (st[ptr] == BK_PROG)  && !prog_fin[ptr];
    partner_erase_act = (st[ptr] == BK_ERASE) && !erase_fin[ptr];
    want_prog  = fire && (op == OP_PROG);
    want_erase = fire && (op == OP_ERASE);
    want_read  = fire && (op == OP_READ);
    prog_ok    = want_prog  && !tgt_busy && !partner_prog_act;
    erase_ok   = want_erase && !tgt_busy && !partner_erase_act;
    seq_err    = (want_prog || want_erase) && !(prog_ok || erase_ok);
    rd_ok      = want_read && !tgt_busy;
    acc_err    = want_read && tgt_busy;
  end

  for (genvar i = 0; i < NBANKS; i++) begin : gen_bank
    localparam int OTH = NBANKS - 1 - i;
    logic sel;
    assign sel              = (cmd_bank == 1'(i));
    assign go_prog[i]       = prog_ok && sel;
    assign go_erase[i]      = erase_ok && sel && !partner_prog_act;
    assign go_erase_held[i] = erase_ok && sel && partner_prog_act;
    assign suspend[i]       = prog_ok && !sel;
    assign resume[i]        = prog_fin[OTH];

    fsch_bank #(
      .PROG_CYCLES (PROG_CYCLES),
      .ERASE_CYCLES(ERASE_CYCLES),
      .CNT_W       (CNT_W)
    ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .go_prog      (go_prog[i]),
      .go_erase     (go_erase[i]),
      .go_erase_held(go_erase_held[i]),
      .suspend      (suspend[i]),
      .resume       (resume[i]),
      .st           (st[i]),
      .prog_fin     (prog_fin[i]),
      .erase_fin    (erase_fin[i])
    );

    assign bank_busy[i]        = (st[i] != BK_IDLE);
    assign bank_programming[i] = (st[i] == BK_PROG);
    assign bank_erasing[i]     = (st[i] == BK_ERASE);
    assign bank_suspended[i]   = (st[i] == BK_ESUSP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_ready <= 1'b0;
      rd_grant  <= 1'b0;
    end else begin
      cmd_ready <= 1'b1;
      rd_grant  <= rd_ok;
    end
  end

  logic [NFLAGS-1:0] flag_set;
  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_DONE] = (|prog_fin) || (|erase_fin);
    flag_set[FLAG_ACC]  = acc_err;
    flag_set[FLAG_SEQ]  = seq_err;
  end

  fsch_flags #(.NF(NFLAGS)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (flag_set),
    .clr  (flag_clr),
    .mask (flag_mask),
    .flags(flags),
    .irq  (irq)
  );

  // R8
  no_dual_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_programming[0] && bank_programming[1]));

  // R8
  no_dual_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_erasing[0] && bank_erasing[1]));

  // R4
  susp_partner0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_suspended[0] |-> bank_programming[1]);

  // R4
  susp_partner1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_suspended[1] |-> bank_programming[0]);

  // R6
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == 2'b01 && bank_busy[cmd_bank]) |=> (!rd_grant && flags[FLAG_ACC]));

  // R7
  seq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op[1] && bank_busy[cmd_bank]) |=> flags[FLAG_SEQ]);
endmodule

// File: tb/flash_bank_sched_bench.sv
`timescale 1ns/1ps
module flash_bank_sched_bench;
  localparam int PC = 4;
  localparam int EC = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic       cmd_bank = 1'b0;
  logic       rd_grant;
  logic [1:0] bank_busy, bank_erasing, bank_programming, bank_suspended;
  logic [2:0] flag_mask = 3'b000;
  logic [2:0] flag_clr = 3'b000;
  logic [2:0] flags;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cnt_er [2];
  int cnt_pr [2];
  int cnt_su [2];

  always #2 clk = ~clk;

  flash_bank_sched #(
    .PAGE_BYTES(32), .WORD_BYTES(8), .CYC_PER_WORD(1), .ERASE_CYCLES(EC)
  ) u_flash_bank_sched (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .rd_grant(rd_grant),
    .bank_busy(bank_busy), .bank_erasing(bank_erasing),
    .bank_programming(bank_programming), .bank_suspended(bank_suspended),
    .flag_mask(flag_mask), .flag_clr(flag_clr), .flags(flags), .irq(irq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      for (int b = 0; b < 2; b++) begin
        if (bank_erasing[b])     cnt_er[b]++;
        if (bank_programming[b]) cnt_pr[b]++;
        if (bank_suspended[b])   cnt_su[b]++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_cnt;
    for (int b = 0; b < 2; b++) begin
      cnt_er[b] = 0; cnt_pr[b] = 0; cnt_su[b] = 0;
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic bk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = bk;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic wait_idle;
    for (int k = 0; k < 500 && bank_busy != 2'b00; k++) @(negedge clk);
  endtask

  task automatic clear_flags;
    flag_clr = 3'b111;
    @(negedge clk);
    flag_clr = 3'b000;
  endtask

  // {op, bank, grant, prog cycles, erase cycles, flags}
  localparam logic [22:0] VEC [8] = '{
    {2'b01, 1'b0, 1'b1, 8'd0,  8'd0,  3'b000},
    {2'b01, 1'b1, 1'b1, 8'd0,  8'd0,  3'b000},
    {2'b10, 1'b0, 1'b0, 8'(PC), 8'd0,  3'b001},
    {2'b10, 1'b1, 1'b0, 8'(PC), 8'd0,  3'b001},
    {2'b11, 1'b0, 1'b0, 8'd0,  8'(EC), 3'b001},
    {2'b11, 1'b1, 1'b0, 8'd0,  8'(EC), 3'b001},
    {2'b00, 1'b0, 1'b0, 8'd0,  8'd0,  3'b000},
    {2'b00, 1'b1, 1'b0, 8'd0,  8'd0,  3'b000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(cmd_ready), 0);
    chk("R1 busy in reset", 32'(bank_busy), 0);
    chk("R1 flags in reset", 32'(flags), 0);
    chk("R1 irq in reset", 32'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(cmd_ready), 1);
    chk("R1 status after reset", 32'({bank_erasing, bank_programming, bank_suspended, rd_grant}), 0);

    // Table: R2 R3 R6 R10 from idle
    for (int i = 0; i < 8; i++) begin
      logic g;
      clear_flags;
      reset_cnt;
      issue(VEC[i][22:21], VEC[i][20]);
      g = rd_grant;
      @(negedge clk);
      chk("R6 grant pulse one cycle", 32'(rd_grant), 0);
      wait_idle;
      chk("R6 R10 grant", 32'(g), 32'(VEC[i][19]));
      chk("R2 program cycles", 32'(cnt_pr[VEC[i][20]]), 32'(VEC[i][18:11]));
      chk("R3 erase cycles", 32'(cnt_er[VEC[i][20]]), 32'(VEC[i][10:3]));
      chk("R2 R3 R10 flags", 32'(flags), 32'(VEC[i][2:0]));
    end

    // R4 suspend and resume
    clear_flags; reset_cnt;
    issue(2'b11, 1'b0);
    @(negedge clk);
    issue(2'b10, 1'b1);
    chk("R4 suspended on program", 32'(bank_suspended[0]), 1);
    chk("R4 not erasing while suspended", 32'(bank_erasing[0]), 0);
    wait_idle;
    chk("R4 suspend length", 32'(cnt_su[0]), PC);
    chk("R4 total erase cycles", 32'(cnt_er[0]), EC);
    chk("R4 program cycles", 32'(cnt_pr[1]), PC);

    // R5 erase held behind program
    clear_flags; reset_cnt;
    issue(2'b10, 1'b0);
    issue(2'b11, 1'b1);
    chk("R5 erase starts suspended", 32'(bank_suspended[1]), 1);
    wait_idle;
    chk("R5 held cycles", 32'(cnt_su[1]), PC - 1);
    chk("R5 erase cycles", 32'(cnt_er[1]), EC);
    chk("R5 no seq error", 32'(flags[2]), 0);

    // R6 reads against busy banks
    clear_flags; reset_cnt;
    issue(2'b11, 1'b0);
    issue(2'b01, 1'b0);
    chk("R6 read erasing bank grant", 32'(rd_grant), 0);
    chk("R6 read erasing bank flag", 32'(flags[1]), 1);
    issue(2'b01, 1'b1);
    chk("R6 read other bank grant", 32'(rd_grant), 1);
    issue(2'b10, 1'b1);
    flag_clr = 3'b010; @(negedge clk); flag_clr = 3'b000;
    issue(2'b01, 1'b0);
    chk("R6 read suspended bank flag", 32'(flags[1]), 1);
    chk("R6 read suspended bank grant", 32'(rd_grant), 0);
    wait_idle;

    // R7 request to busy bank
    clear_flags; reset_cnt;
    issue(2'b10, 1'b0);
    issue(2'b10, 1'b0);
    chk("R7 seq error on busy program", 32'(flags[2]), 1);
    issue(2'b11, 1'b0);
    wait_idle;
    chk("R7 program not restarted", 32'(cnt_pr[0]), PC);
    chk("R7 erase ignored", 32'(cnt_er[0] + cnt_su[0]), 0);

    // R8 disallowed combinations
    clear_flags; reset_cnt;
    issue(2'b10, 1'b0);
    issue(2'b10, 1'b1);
    chk("R8 dual program flag", 32'(flags[2]), 1);
    wait_idle;
    chk("R8 second program ignored", 32'(cnt_pr[1]), 0);
    clear_flags; reset_cnt;
    issue(2'b11, 1'b0);
    issue(2'b11, 1'b1);
    chk("R8 dual erase flag", 32'(flags[2]), 1);
    wait_idle;
    chk("R8 second erase ignored", 32'(cnt_er[1] + cnt_su[1]), 0);

    // R9 masking, clearing, set wins
    clear_flags;
    flag_mask = 3'b111;
    issue(2'b10, 1'b0);
    wait_idle;
    chk("R9 done flag sticky", 32'(flags), 1);
    chk("R9 irq masked", 32'(irq), 0);
    flag_mask = 3'b110;
    @(negedge clk);
    chk("R9 irq unmasked", 32'(irq), 1);
    issue(2'b11, 1'b1);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_bank = 1'b1; flag_clr = 3'b010;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00; flag_clr = 3'b000;
    chk("R9 set wins over clear", 32'(flags[1]), 1);
    flag_clr = 3'b010; @(negedge clk); flag_clr = 3'b000;
    chk("R9 clear one bit", 32'(flags[1]), 0);
    chk("R9 other bit kept", 32'(flags[0]), 1);
    wait_idle;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule